// File: doc/BRIEF.md
# Pipelined Bus Manager with Error-Warning Cancellation

This block issues single transfers onto a pipelined AHB-Lite bus on behalf of a request source that presents one request at a time (address, direction, write data) with a valid/ready handshake. A request is driven as a NONSEQ address phase. It is popped from the source when the bus accepts that phase, and its write data is driven during the following data phase. An OKAY response lets the next request go ahead with no further action.

When the subordinate answers with ERROR while holding HREADY low, the block treats that cycle as a warning. In the next cycle it turns the address phase that was already lined up behind the failing transfer into IDLE, so that transfer never commits. When the failing transfer completes, the block raises a one-cycle fault pulse carrying the address and direction of that transfer. The block assumes no rollback: it only reports the failing access. A mode input selects what happens to the cancelled request. It is either dropped from the source or left at the head to be issued again. ERROR seen with HREADY high and no warning before it sets a sticky protocol-violation flag.

Top module: `ahb_err_issuer`

## Requirements
- R1: After reset, with no request valid, htrans is IDLE (2'b00), reqReady is 0, faultPulse is 0 and protoErr is 0.
- R2: While reqValid is high and no error completion is pending, htrans is NONSEQ (2'b10) with haddr and hwrite taken from the head request, and reqReady is high exactly in cycles where hready is also high.
- R3: While hready is low and hresp is OKAY, a NONSEQ address phase stays NONSEQ with haddr and hwrite unchanged in the next cycle, and the head is not popped.
- R4: During the data phase of a write, hwdata equals the write data of the request whose address phase was accepted one cycle earlier.
- R5: In the cycle after hresp=ERROR is seen with hready low during a data phase, htrans is IDLE, even with a request valid.
- R6: One cycle after the completing ERROR cycle (hresp and hready both high after a warning), faultPulse is high for exactly one cycle, with faultAddr and faultWrite equal to the failing transfer's address and direction.
- R7: With reissueMode=0, a request that was presented as NONSEQ in the warning cycle is popped (reqReady high) in the completing cycle without being issued. If no request was presented in the warning cycle, nothing is popped then.
- R8: With reissueMode=1, the cancelled request is not popped in the completing cycle and is issued again as NONSEQ in the next cycle.
- R9: An OKAY completion raises no fault and the next request is issued and accepted without a gap.
- R10: hresp=ERROR with hready high and no warning cycle before it sets protoErr, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reissueMode | input | 1 | 1: keep cancelled request for reissue, 0: drop it |
| reqValid | input | 1 | Head request present |
| reqAddr | input | ADDR_W | Head request address |
| reqWrite | input | 1 | Head request is a write |
| reqWdata | input | DATA_W | Head request write data |
| reqReady | output | 1 | Pop the head request |
| htrans | output | 2 | Transfer type, IDLE 2'b00 / NONSEQ 2'b10 |
| haddr | output | ADDR_W | Bus address |
| hwrite | output | 1 | Bus direction |
| hwdata | output | DATA_W | Bus write data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus response, 1 = ERROR |
| faultPulse | output | 1 | One-cycle fault indication |
| faultAddr | output | ADDR_W | Address of the failing transfer |
| faultWrite | output | 1 | Direction of the failing transfer |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
If the pending-error flag is lost, the completion cycle shows NONSEQ on htrans instead of IDLE, and faultPulse fails to appear one cycle later. Both are visible within two cycles of the warning. If the flag that records a lined-up request is wrong, reqReady is high or low in the wrong place during the completion cycle, and the mix-up shows up in the same cycle. A stale data-phase register shows up as a wrong faultAddr or hwdata in the cycle after the transfer was accepted. The stimulus covers each response order: wait states, warnings with and without a lined-up request, both cancellation modes, and an ERROR with no warning.

// File: rtl/ahb_err_issuer_pkg.sv
package ahb_err_issuer_pkg;
  typedef enum logic [1:0] {
    TRANS_IDLE   = 2'b00,
    TRANS_NONSEQ = 2'b10
  } trans_e;

  typedef struct packed {
    logic issue;      // drive the head as a NONSEQ address phase
    logic capture;    // bus advances this cycle (hready high)
    logic faultFire;  // errored transfer completes this cycle
    logic popHead;    // remove head from the request source
  } strobe_t;
endpackage

// File: rtl/ahb_err_issuer_ctrl.sv
module ahb_err_issuer_ctrl
  import ahb_err_issuer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    hready,
  input  logic    hresp,
  input  logic    reissueMode,
  input  logic    dataValid,
  output strobe_t strb,
  output logic    protoErr
);
  logic errSeen;    // warning cycle observed, completion pending
  logic cancelled;  // a request was lined up behind the failing one
  logic warnNow;
  logic doneErr;

  assign warnNow = dataValid && !hready && hresp && !errSeen;
  assign doneErr = errSeen && hready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errSeen   <= 1'b0;
      cancelled <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      if (warnNow) begin
        errSeen   <= 1'b1;
        cancelled <= reqValid;
      end else if (doneErr) begin
        errSeen   <= 1'b0;
        cancelled <= 1'b0;
      end
      if (hready && hresp && !errSeen)
        protoErr <= 1'b1;
    end
  end

  always_comb begin
    strb.issue     = reqValid && !errSeen;
    strb.capture   = hready;
    strb.faultFire = doneErr;
    strb.popHead   = (strb.issue && hready) ||
                     (doneErr && cancelled && !reissueMode);
  end
endmodule

// File: rtl/ahb_err_issuer_datapath.sv
module ahb_err_issuer_datapath
  import ahb_err_issuer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              dataValid,
  output logic [DATA_W-1:0] hwdata,
  output logic              faultPulse,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultWrite
);
  logic [ADDR_W-1:0] dataAddr;
  logic              dataWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid  <= 1'b0;
      dataAddr   <= '0;
      dataWrite  <= 1'b0;
      hwdata     <= '0;
      faultPulse <= 1'b0;
      faultAddr  <= '0;
      faultWrite <= 1'b0;
    end else begin
      if (strb.capture) begin
        dataValid <= strb.issue;
        if (strb.issue) begin
          dataAddr  <= reqAddr;
          dataWrite <= reqWrite;
          hwdata    <= reqWdata;
        end
      end
      faultPulse <= strb.faultFire;
      if (strb.faultFire) begin
        faultAddr  <= dataAddr;
        faultWrite <= dataWrite;
      end
    end
  end
endmodule

// File: rtl/ahb_err_issuer.sv
module ahb_err_issuer
  import ahb_err_issuer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reissueMode,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic              hresp,
  output logic              faultPulse,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultWrite,
  output logic              protoErr
);
  strobe_t strb;
  logic    dataValid;

  ahb_err_issuer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hready(hready),
    .hresp(hresp), .reissueMode(reissueMode), .dataValid(dataValid),
    .strb(strb), .protoErr(protoErr)
  );

  ahb_err_issuer_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .dataValid(dataValid),
    .hwdata(hwdata), .faultPulse(faultPulse), .faultAddr(faultAddr),
    .faultWrite(faultWrite)
  );

  assign htrans   = strb.issue ? TRANS_NONSEQ : TRANS_IDLE;
  assign haddr    = reqAddr;
  assign hwrite   = reqWrite;
  assign reqReady = strb.popHead;
endmodule

// File: rtl/ahb_err_issuer_chk.sv
module ahb_err_issuer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        htrans,
  input logic [ADDR_W-1:0] haddr,
  input logic              hwrite,
  input logic              hready,
  input logic              hresp,
  input logic              reqReady,
  input logic              dataValid,
  input logic              faultPulse,
  input logic              protoErr
);
  // R5: warning cycle is followed by an IDLE address phase
  p_cancel_after_warn_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !hready && hresp) |=> (htrans == 2'b00));

  // R3: stalled address phase held stable when no error is signalled
  p_hold_on_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b10 && !hready && !hresp) |=>
      (htrans == 2'b10 && $stable(haddr) && $stable(hwrite)));

  // R6: fault only follows an ERROR completion and lasts one cycle
  p_fault_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(hready && hresp));
  p_fault_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> !faultPulse);

  // R2: pops only happen in cycles where the bus advances
  p_pop_on_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> hready);

  // R10: violation flag is sticky
  p_proto_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind ahb_err_issuer ahb_err_issuer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
  .hready(hready), .hresp(hresp), .reqReady(reqReady),
  .dataValid(dataValid), .faultPulse(faultPulse), .protoErr(protoErr)
);

// File: tb/ahb_err_issuer_bench.sv
module ahb_err_issuer_bench;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct packed {
    logic       rv;
    logic [7:0] addr;
    logic       wr;
    logic       rdy;
    logic       rsp;
    logic       reissue;
    logic       eNonseq;
    logic       ePop;
    logic       eFault;
    logic [7:0] eFA;
    logic       eFW;
    logic       chkWd;
    logic [7:0] eWd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // rv addr  wr rdy rsp ris nsq pop flt  fA   fW cwd  wd
    '{1'b1,8'h10,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,8'h00}, // 0 R2
    '{1'b1,8'h14,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,1'b1,8'h10}, // 1 R4 R9
    '{1'b1,8'h18,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 2 R3 wait
    '{1'b1,8'h18,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,8'h00}, // 3 R3
    '{1'b1,8'h1C,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,8'h18}, // 4 warning
    '{1'b1,8'h1C,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,8'h00}, // 5 R5 R7
    '{1'b1,8'h20,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'h18,1'b1,1'b0,8'h00}, // 6 R6
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 7 R9
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 8
    '{1'b1,8'h30,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,8'h00}, // 9
    '{1'b1,8'h34,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 10 warning
    '{1'b1,8'h34,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 11 R8 no pop
    '{1'b1,8'h34,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,8'h30,1'b1,1'b0,8'h00}, // 12 R8 reissue
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 13
    '{1'b1,8'h40,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,8'h00}, // 14
    '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 15 warning, none queued
    '{1'b1,8'h44,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}, // 16 R7 no pop
    '{1'b1,8'h44,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'h40,1'b0,1'b0,8'h00}, // 17 R6
    '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00}  // 18
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reissueMode = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic hready = 1'b1, hresp = 1'b0;
  logic reqReady, hwrite, faultPulse, faultWrite, protoErr;
  logic [1:0] htrans;
  logic [AW-1:0] haddr, faultAddr;
  logic [DW-1:0] hwdata;

  int applied = 0, miscompares = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ahb_err_issuer #(.ADDR_W(AW), .DATA_W(DW)) u_ahb_err_issuer (
    .clk(clk), .rstN(rstN), .reissueMode(reissueMode), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqReady(reqReady), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
    .hwdata(hwdata), .hready(hready), .hresp(hresp), .faultPulse(faultPulse),
    .faultAddr(faultAddr), .faultWrite(faultWrite), .protoErr(protoErr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [7:0] a, input logic wr,
                       input logic rdy, input logic rsp, input logic ris);
    reqValid = rv; reqAddr = {24'h0, a}; reqWrite = wr;
    reqWdata = {a, a, a, a}; hready = rdy; hresp = rsp; reissueMode = ris;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    #(PERIOD*2000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R1 htrans idle after reset", 64'(htrans), 64'h0);
    check("R1 reqReady after reset", 64'(reqReady), 64'h0);
    check("R1 faultPulse after reset", 64'(faultPulse), 64'h0);
    check("R1 protoErr after reset", 64'(protoErr), 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].rv, VEC[i].addr, VEC[i].wr, VEC[i].rdy, VEC[i].rsp, VEC[i].reissue);
      #(PERIOD/2 - 1);
      check($sformatf("R2 R5 htrans row %0d", i), 64'(htrans),
            VEC[i].eNonseq ? 64'h2 : 64'h0);
      check($sformatf("R7 R8 reqReady row %0d", i), 64'(reqReady), 64'(VEC[i].ePop));
      check($sformatf("R6 R9 faultPulse row %0d", i), 64'(faultPulse), 64'(VEC[i].eFault));
      if (VEC[i].eNonseq) begin
        check($sformatf("R2 haddr row %0d", i), 64'(haddr), 64'(VEC[i].addr));
        check($sformatf("R2 hwrite row %0d", i), 64'(hwrite), 64'(VEC[i].wr));
      end
      if (VEC[i].eFault) begin
        check($sformatf("R6 faultAddr row %0d", i), 64'(faultAddr), 64'(VEC[i].eFA));
        check($sformatf("R6 faultWrite row %0d", i), 64'(faultWrite), 64'(VEC[i].eFW));
      end
      if (VEC[i].chkWd)
        check($sformatf("R4 hwdata row %0d", i), 64'(hwdata),
              64'({VEC[i].eWd, VEC[i].eWd, VEC[i].eWd, VEC[i].eWd}));
    end

    check("R10 protoErr clear after legal errors", 64'(protoErr), 64'h0);

    // R10: ERROR with hready high and no warning cycle
    @(negedge clk); drive(1'b1, 8'h50, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    #1;
    check("R10 protoErr set", 64'(protoErr), 64'h1);
    check("R6 no fault without warning", 64'(faultPulse), 64'h0);
    repeat (2) @(negedge clk);
    #1;
    check("R10 protoErr sticky", 64'(protoErr), 64'h1);

    done = 1'b1;
    summary();
  end
endmodule